// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block plays the target's part on a SCSI-1 bus. It is a phase state machine. From the initiator it takes the BSY, SEL and ATN levels, the ACK strobe and the 8-bit data bus. It recognises arbitration and selection, and picks a responding target ID from a mask of device IDs that are present. It then runs the information phases in a fixed order: command, then data in or data out, then status, then message-in. After message-in it releases the bus.

The attached target sees a plain byte-buffer port. It supplies the transfer direction and a status byte when the command finishes. It returns the read byte for the current offset, and it receives written bytes as single-cycle strobes. The transfer length comes from the command bytes unless the target supplies a length of its own.

A local read port can look at the current inbound byte without moving on. A one-cycle consume strobe moves on without an ACK. Everything else moves forward on ACK edges.

Top module: `scsi_tseq_top`

## Requirements
- R1: In bus free (phase code 0), BSY high with SEL low moves to arbitration (code 1) only when exactly one data bus bit is set. That bit's index becomes the initiator ID, reported on `init_id_o` with `init_vld_o` high. Any other mask leaves the bus free. In arbitration, SEL high moves to selection (code 2), and BSY low with SEL low returns to bus free.
- R2: In bus free, SEL high with BSY low moves to selection (code 2) only when the data bus is non-zero and has at most two bits set. Otherwise the bus stays free.
- R3: In selection, once BSY is low, the target is the lowest-numbered data bus bit that is set in `present_i` and is not the initiator ID from R1. That target moves the bus to command (code 3) with its ID on `tgt_id_o`. If no such bit exists, the bus returns to free.
- R4: The first command byte's top three bits select the command size: 000 means 6 bytes, any other value means 10 bytes. The length is byte 4 for a 6-byte command and bytes 7 (high) and 8 (low) for a 10-byte command. When `len_ovr_vld_i` is high at the last command byte, `len_ovr_i` is used instead.
- R5: After the last command byte, the next phase is status (code 6) if the length is zero. Otherwise it is data in (code 5) when `dir_in_i` is high, or data out (code 4) when it is low. During a data phase, the offset on `tgt_idx_o` advances only when a byte is consumed or transferred. Reaching the length moves the bus to status. Leaving the inbound byte unconsumed changes nothing, and `rd_data_o` shows `tgt_rd_data_i` in data in.
- R6: In status, `rd_data_o` shows the status byte taken from `tgt_status_i` at the last command byte. Consuming it clears it and moves to message-in (code 7), where `rd_data_o` is 0x00. Consuming the message byte returns the bus to free.
- R7: A rising ACK edge in command or data out stores or writes the data bus byte only if `dbus_drv_i` is high. In data out, the byte is written through `wr_en_o` and `wr_data_o`. A rising ACK edge or a `rd_next_i` pulse in data in, status or message-in consumes the current byte. A falling ACK edge has no effect.
- R8: REQ is high in every information phase (codes 3 to 7) except from the cycle after a rising ACK edge until ACK has been seen low. REQ is never high while BSY out is low.
- R9: The synchronous reset forces bus free, clears both IDs, the offset and the status byte, and drives REQ and BSY low.
- R10: The phase lines follow the phase code: command sets C/D only, data out sets none, data in sets I/O only, status sets I/O and C/D, and message-in sets all three. BSY out is high exactly in codes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bsy_i | input | 1 | Initiator BSY level |
| sel_i | input | 1 | Initiator SEL level |
| atn_i | input | 1 | Initiator ATN level |
| ack_i | input | 1 | Initiator ACK level |
| dbus_i | input | DATA_W | Data bus from the initiator |
| dbus_drv_i | input | 1 | High while the initiator drives the data bus |
| present_i | input | DATA_W | One bit per bus ID that has a device |
| len_ovr_vld_i | input | 1 | Use the explicit transfer length |
| len_ovr_i | input | LEN_W | Explicit transfer length |
| dir_in_i | input | 1 | Data direction at command end, 1 = toward initiator |
| tgt_status_i | input | 8 | Status byte captured at command end |
| tgt_rd_data_i | input | DATA_W | Target byte at offset `tgt_idx_o` |
| rd_next_i | input | 1 | Consume the current inbound byte |
| phase_o | output | 3 | Phase code |
| io_o | output | 1 | I/O phase line |
| cd_o | output | 1 | C/D phase line |
| msg_o | output | 1 | MSG phase line |
| req_o | output | 1 | REQ |
| bsy_o | output | 1 | Target BSY |
| atn_lat_o | output | 1 | ATN level captured when selection resolves |
| rd_data_o | output | DATA_W | Current inbound byte |
| tgt_idx_o | output | LEN_W | Transfer offset |
| wr_en_o | output | 1 | Data out byte strobe |
| wr_data_o | output | DATA_W | Data out byte |
| init_id_o | output | IDW | Initiator ID from arbitration |
| init_vld_o | output | 1 | Initiator ID valid |
| tgt_id_o | output | IDW | Selected target ID |

## Verification
The assertions check these rules on every cycle:
- arbitration is entered only from a one-hot mask, and selection only from a mask of one or two bits;
- a selected target is always marked present;
- REQ falls after every rising ACK and never appears without BSY;
- a falling ACK never moves an information phase;
- message-in is entered only from status and always exits to bus free;
- the phase is free right after reset.

Only the bench's scenarios can show the rest:
- exclusion of the initiator and the choice of the lowest ID;
- the length taken from 6-byte and 10-byte commands, or from the explicit length;
- peek without consume;
- that data out writes nothing when the bus is not driven;
- the exact bytes returned in each inbound phase.

// File: rtl/scsi_tseq_pkg.sv
package scsi_tseq_pkg;

   typedef enum logic [2:0] {
      PH_FREE = 3'd0,
      PH_ARB  = 3'd1,
      PH_SEL  = 3'd2,
      PH_CMD  = 3'd3,
      PH_DOUT = 3'd4,
      PH_DIN  = 3'd5,
      PH_STAT = 3'd6,
      PH_MSGI = 3'd7
   } bus_ph_e;

   localparam logic [2:0] GRP_SHORT = 3'd0;
   localparam logic [3:0] SHORT_LAST_IDX = 4'd5;
   localparam logic [3:0] LONG_LAST_IDX  = 4'd9;
   localparam logic [3:0] IDX_LEN6  = 4'd4;
   localparam logic [3:0] IDX_LENHI = 4'd7;
   localparam logic [3:0] IDX_LENLO = 4'd8;

endpackage

// File: rtl/scsi_id_scan.sv
module scsi_id_scan #(
   parameter int W   = 8,
   parameter int IDW = $clog2(W),
   parameter int CW  = $clog2(W + 1)
) (
   input  logic [W-1:0]   mask,
   output logic [CW-1:0]  cnt,
   output logic [IDW-1:0] low_idx
);

   logic [W-1:0] first;

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_first
         if (g == 0) begin : g_lsb
            assign first[g] = mask[g];
         end else begin : g_upper
            assign first[g] = mask[g] & ~(|mask[g-1:0]);
         end
      end
   endgenerate

   always_comb begin
      cnt     = '0;
      low_idx = '0;
      for (int i = 0; i < W; i++) begin
         cnt = cnt + CW'(mask[i]);
         if (first[i]) low_idx = low_idx | IDW'(i);
      end
   end

endmodule

// File: rtl/scsi_len_calc.sv
module scsi_len_calc
   import scsi_tseq_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [2:0]       grp,
   input  logic [7:0]       b4,
   input  logic [7:0]       b7,
   input  logic [7:0]       b8,
   input  logic             ovr_vld,
   input  logic [LEN_W-1:0] ovr_len,
   output logic             short_cmd,
   output logic [LEN_W-1:0] len
);

   generate
      if (LEN_W < 16) begin : g_bad_len
         $error("scsi_len_calc: LEN_W must hold a 16-bit length");
      end
   endgenerate

   assign short_cmd = (grp == GRP_SHORT);

   always_comb begin
      if (ovr_vld)        len = ovr_len;
      else if (short_cmd) len = LEN_W'(b4);
      else                len = LEN_W'({b7, b8});
   end

endmodule

// File: rtl/scsi_tseq_top.sv
module scsi_tseq_top
   import scsi_tseq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 16,
   parameter int IDW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bsy_i,
   input  logic              sel_i,
   input  logic              atn_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] dbus_i,
   input  logic              dbus_drv_i,
   input  logic [DATA_W-1:0] present_i,
   input  logic              len_ovr_vld_i,
   input  logic [LEN_W-1:0]  len_ovr_i,
   input  logic              dir_in_i,
   input  logic [7:0]        tgt_status_i,
   input  logic [DATA_W-1:0] tgt_rd_data_i,
   input  logic              rd_next_i,
   output logic [2:0]        phase_o,
   output logic              io_o,
   output logic              cd_o,
   output logic              msg_o,
   output logic              req_o,
   output logic              bsy_o,
   output logic              atn_lat_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [LEN_W-1:0]  tgt_idx_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [IDW-1:0]    init_id_o,
   output logic              init_vld_o,
   output logic [IDW-1:0]    tgt_id_o
);

   localparam int CW = $clog2(DATA_W + 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("scsi_tseq_top: SCSI-1 data bus is 8 bits wide");
      end
   endgenerate

   bus_ph_e          state_q;
   logic             ack_q, ack_hold_q, atn_q;
   logic [IDW-1:0]   init_id_q, tgt_id_q;
   logic             init_vld_q;
   logic [LEN_W-1:0] off_q, len_q;
   logic [7:0]       stat_q;
   logic [3:0]       cnt_q;
   logic [2:0]       grp_q;
   logic [7:0]       b4_q, b7_q, b8_q;

   // ID mask scans
   logic [CW-1:0]     bus_cnt, cand_cnt;
   logic [IDW-1:0]    bus_low, cand_low;
   logic [DATA_W-1:0] excl, cand;

   always_comb begin
      excl = '0;
      if (init_vld_q) excl[init_id_q] = 1'b1;
   end
   assign cand = dbus_i & present_i & ~excl;

   scsi_id_scan #(.W(DATA_W), .IDW(IDW), .CW(CW)) u_bus_scan (
      .mask(dbus_i), .cnt(bus_cnt), .low_idx(bus_low));
   scsi_id_scan #(.W(DATA_W), .IDW(IDW), .CW(CW)) u_cand_scan (
      .mask(cand), .cnt(cand_cnt), .low_idx(cand_low));

   logic arb_ok, sel_ok, cand_any;
   assign arb_ok   = (bus_cnt == CW'(1));
   assign sel_ok   = (bus_cnt != '0) && (bus_cnt <= CW'(2));
   assign cand_any = (cand_cnt != '0);

   // Length decode
   logic             short_cmd;
   logic [LEN_W-1:0] len_w;

   scsi_len_calc #(.LEN_W(LEN_W)) u_len (
      .grp(grp_q), .b4(b4_q), .b7(b7_q), .b8(b8_q),
      .ovr_vld(len_ovr_vld_i), .ovr_len(len_ovr_i),
      .short_cmd(short_cmd), .len(len_w));

   // Handshake events
   logic ack_rise, out_take, in_take, cmd_last;
   logic [LEN_W-1:0] off_nx;
   assign ack_rise = ack_i & ~ack_q;
   assign out_take = ack_rise & dbus_drv_i;
   assign in_take  = ack_rise | rd_next_i;
   assign off_nx   = off_q + LEN_W'(1);
   assign cmd_last = (cnt_q != 4'd0) &&
                     (cnt_q == (short_cmd ? SHORT_LAST_IDX : LONG_LAST_IDX));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= PH_FREE;
         ack_q      <= 1'b0;
         ack_hold_q <= 1'b0;
         atn_q      <= 1'b0;
         init_id_q  <= '0;
         init_vld_q <= 1'b0;
         tgt_id_q   <= '0;
         off_q      <= '0;
         len_q      <= '0;
         stat_q     <= '0;
         cnt_q      <= '0;
         grp_q      <= '0;
         b4_q       <= '0;
         b7_q       <= '0;
         b8_q       <= '0;
      end else begin
         ack_q <= ack_i;
         if (ack_rise)    ack_hold_q <= 1'b1;
         else if (!ack_i) ack_hold_q <= 1'b0;

         case (state_q)
            PH_FREE: begin
               if (bsy_i && !sel_i) begin
                  if (arb_ok) begin
                     state_q    <= PH_ARB;
                     init_id_q  <= bus_low;
                     init_vld_q <= 1'b1;
                  end
               end else if (sel_i && !bsy_i && sel_ok) begin
                  state_q    <= PH_SEL;
                  init_vld_q <= 1'b0;
               end
            end
            PH_ARB: begin
               if (sel_i) begin
                  state_q <= PH_SEL;
               end else if (!bsy_i) begin
                  state_q    <= PH_FREE;
                  init_vld_q <= 1'b0;
               end
            end
            PH_SEL: begin
               if (!bsy_i) begin
                  atn_q <= atn_i;
                  if (cand_any) begin
                     state_q  <= PH_CMD;
                     tgt_id_q <= cand_low;
                     cnt_q    <= '0;
                  end else begin
                     state_q    <= PH_FREE;
                     init_vld_q <= 1'b0;
                  end
               end
            end
            PH_CMD: begin
               if (out_take) begin
                  case (cnt_q)
                     4'd0:      grp_q <= dbus_i[7:5];
                     IDX_LEN6:  b4_q  <= dbus_i;
                     IDX_LENHI: b7_q  <= dbus_i;
                     IDX_LENLO: b8_q  <= dbus_i;
                     default: ;
                  endcase
                  cnt_q <= cnt_q + 4'd1;
                  if (cmd_last) begin
                     len_q  <= len_w;
                     off_q  <= '0;
                     stat_q <= tgt_status_i;
                     if (len_w == '0)   state_q <= PH_STAT;
                     else if (dir_in_i) state_q <= PH_DIN;
                     else               state_q <= PH_DOUT;
                  end
               end
            end
            PH_DOUT: begin
               if (out_take) begin
                  off_q <= off_nx;
                  if (off_nx == len_q) state_q <= PH_STAT;
               end
            end
            PH_DIN: begin
               if (in_take) begin
                  off_q <= off_nx;
                  if (off_nx == len_q) state_q <= PH_STAT;
               end
            end
            PH_STAT: begin
               if (in_take) begin
                  stat_q  <= '0;
                  state_q <= PH_MSGI;
               end
            end
            PH_MSGI: begin
               if (in_take) begin
                  state_q    <= PH_FREE;
                  init_vld_q <= 1'b0;
               end
            end
            default: state_q <= PH_FREE;
         endcase
      end
   end

   // Bus-facing outputs
   assign phase_o    = state_q;
   assign bsy_o      = (state_q >= PH_CMD);
   assign io_o       = (state_q == PH_DIN) || (state_q == PH_STAT) || (state_q == PH_MSGI);
   assign cd_o       = (state_q == PH_CMD) || (state_q == PH_STAT) || (state_q == PH_MSGI);
   assign msg_o      = (state_q == PH_MSGI);
   assign req_o      = bsy_o && !ack_hold_q;
   assign atn_lat_o  = atn_q;
   assign init_id_o  = init_id_q;
   assign init_vld_o = init_vld_q;
   assign tgt_id_o   = tgt_id_q;
   assign tgt_idx_o  = off_q;
   assign wr_en_o    = (state_q == PH_DOUT) && out_take;
   assign wr_data_o  = dbus_i;

   always_comb begin
      case (state_q)
         PH_DIN:  rd_data_o = tgt_rd_data_i;
         PH_STAT: rd_data_o = stat_q;
         default: rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/scsi_tseq_chk.sv
module scsi_tseq_chk #(
   parameter int DATA_W = 8,
   parameter int IDW    = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              ack_i,
   input logic              rd_next_i,
   input logic [DATA_W-1:0] dbus_i,
   input logic [DATA_W-1:0] present_i,
   input logic [2:0]        phase_o,
   input logic              req_o,
   input logic              bsy_o,
   input logic [IDW-1:0]    tgt_id_o
);

   localparam logic [2:0] C_FREE = 3'd0;
   localparam logic [2:0] C_ARB  = 3'd1;
   localparam logic [2:0] C_SEL  = 3'd2;
   localparam logic [2:0] C_CMD  = 3'd3;
   localparam logic [2:0] C_STAT = 3'd6;
   localparam logic [2:0] C_MSGI = 3'd7;

   AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      (phase_o == C_ARB && $past(phase_o) == C_FREE) |-> $onehot($past(dbus_i))); // R1

   AST_SEL_MASK: assert property (@(posedge clk) disable iff (rst)
      (phase_o == C_SEL && $past(phase_o) == C_FREE) |->
         ($past(dbus_i) != '0 && $countones($past(dbus_i)) <= 2)); // R2

   AST_TGT_PRESENT: assert property (@(posedge clk) disable iff (rst)
      (phase_o == C_CMD && $past(phase_o) == C_SEL) |->
         (($past(present_i) >> tgt_id_o) & DATA_W'(1)) != '0); // R3

   AST_MSG_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (phase_o == C_MSGI && $past(phase_o) != C_MSGI) |-> $past(phase_o) == C_STAT); // R6

   AST_MSG_EXIT: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_o) == C_MSGI && phase_o != C_MSGI) |-> phase_o == C_FREE); // R6

   AST_ACK_FALL_NOP: assert property (@(posedge clk) disable iff (rst)
      ($fell(ack_i) && !rd_next_i && phase_o >= C_CMD) |=> $stable(phase_o)); // R7

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
      $rose(ack_i) |=> !req_o); // R8

   AST_REQ_NEEDS_BSY: assert property (@(posedge clk) disable iff (rst)
      req_o |-> bsy_o); // R8

   AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (phase_o == C_FREE && !bsy_o)); // R9

endmodule

bind scsi_tseq_top scsi_tseq_chk #(.DATA_W(DATA_W), .IDW(IDW)) u_chk (.*);

// File: tb/tb_scsi_tseq_top.sv
`timescale 1ns/1ps
module tb_scsi_tseq_top;

   localparam int DW = 8;
   localparam int LW = 16;
   localparam logic [2:0] FREE = 3'd0, ARB = 3'd1, SEL = 3'd2, CMD = 3'd3,
                          DOUT = 3'd4, DIN = 3'd5, STAT = 3'd6, MSGI = 3'd7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bsy_i = 0, sel_i = 0, atn_i = 0, ack_i = 0, dbus_drv_i = 0;
   logic [DW-1:0] dbus_i = '0, present_i = '0;
   logic len_ovr_vld_i = 0, dir_in_i = 0, rd_next_i = 0;
   logic [LW-1:0] len_ovr_i = '0;
   logic [7:0] tgt_status_i = '0;
   logic [DW-1:0] tgt_rd_data_i;
   logic [2:0] phase_o;
   logic io_o, cd_o, msg_o, req_o, bsy_o, atn_lat_o, wr_en_o, init_vld_o;
   logic [DW-1:0] rd_data_o, wr_data_o;
   logic [LW-1:0] tgt_idx_o;
   logic [2:0] init_id_o, tgt_id_o;

   always #4 clk = ~clk;

   assign tgt_rd_data_i = 8'hA0 + tgt_idx_o[7:0];

   scsi_tseq_top dut (.*);

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      logic [2:0] ph;
      logic       bsy;
      logic       req;
      logic       chk_rd;
      logic [7:0] rd;
      string      tag;
   } exp_t;
   exp_t q[$];

   logic [7:0] wlog[8];
   int wn = 0;
   always @(posedge clk) if (!rst && wr_en_o && wn < 8) begin
      wlog[wn] = wr_data_o;
      wn++;
   end

   // Monitor: compare queued expectations away from the clock edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         logic eio, ecd, emsg;
         e = q.pop_front();
         eio  = (e.ph == DIN) || (e.ph == STAT) || (e.ph == MSGI);
         ecd  = (e.ph == CMD) || (e.ph == STAT) || (e.ph == MSGI);
         emsg = (e.ph == MSGI);
         total++;
         if (phase_o !== e.ph || bsy_o !== e.bsy || req_o !== e.req) begin
            bad++;
            $display("FAIL %s: phase/bsy/req act=%0d/%0b/%0b exp=%0d/%0b/%0b",
                     e.tag, phase_o, bsy_o, req_o, e.ph, e.bsy, e.req);
         end
         total++;
         if ({io_o, cd_o, msg_o} !== {eio, ecd, emsg}) begin
            bad++;
            $display("FAIL R10 (%s): io/cd/msg act=%b exp=%b", e.tag,
                     {io_o, cd_o, msg_o}, {eio, ecd, emsg});
         end
         if (e.chk_rd) begin
            total++;
            if (rd_data_o !== e.rd) begin
               bad++;
               $display("FAIL %s: rd_data act=%02h exp=%02h", e.tag, rd_data_o, e.rd);
            end
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_st(input logic [2:0] ph, input logic bsy, input logic req,
                            input logic chk_rd, input logic [7:0] rd, input string tag);
      exp_t e;
      e.ph = ph; e.bsy = bsy; e.req = req; e.chk_rd = chk_rd; e.rd = rd; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // One ACK handshake: rise then fall
   task automatic ack_byte(input logic [7:0] b, input logic drv);
      dbus_i = b; dbus_drv_i = drv; ack_i = 1'b1;
      cyc();
      chk(req_o == 1'b0, "R8 req low after ack rise", req_o, 0);
      ack_i = 1'b0;
      cyc();
      dbus_drv_i = 1'b0;
   endtask

   task automatic sel_from_free(input logic [7:0] mask);
      sel_i = 1'b1; bsy_i = 1'b0; dbus_i = mask;
      cyc();
      cyc();
      sel_i = 1'b0;
   endtask

   initial begin
      repeat (3) cyc();
      expect_st(FREE, 0, 0, 1, 8'h00, "R9 reset state");
      rst = 1'b0;
      cyc();

      // R1: arbitration mask validation
      bsy_i = 1; dbus_i = 8'h03; cyc();
      expect_st(FREE, 0, 0, 0, 0, "R1 two-bit arbitration ignored");
      dbus_i = 8'h00; cyc();
      expect_st(FREE, 0, 0, 0, 0, "R1 empty arbitration ignored");
      dbus_i = 8'h80; cyc();
      expect_st(ARB, 0, 0, 0, 0, "R1 one-hot arbitration");
      chk(init_vld_o && init_id_o == 3'd7, "R1 initiator id", init_id_o, 7);
      bsy_i = 0; dbus_i = 8'h00; cyc();
      expect_st(FREE, 0, 0, 0, 0, "R1 release arbitration");

      // R2: selection mask validation
      sel_i = 1; dbus_i = 8'h07; cyc();
      expect_st(FREE, 0, 0, 0, 0, "R2 three-bit selection ignored");
      dbus_i = 8'h00; cyc();
      expect_st(FREE, 0, 0, 0, 0, "R2 zero selection ignored");
      sel_i = 0; cyc();

      // R3: no present device -> free
      present_i = 8'h00; sel_i = 1; dbus_i = 8'h06; cyc();
      expect_st(SEL, 0, 0, 0, 0, "R2 two-bit selection");
      cyc();
      expect_st(FREE, 0, 0, 0, 0, "R3 no target responds");
      sel_i = 0; cyc();

      // R3 lowest present, then 6-byte read command
      present_i = 8'h24; dir_in_i = 1; tgt_status_i = 8'h02;
      sel_from_free(8'h24);
      expect_st(CMD, 1, 1, 0, 0, "R3 command after select");
      chk(tgt_id_o == 3'd2, "R3 lowest present target", tgt_id_o, 2);
      ack_byte(8'h08, 1); ack_byte(8'h00, 1); ack_byte(8'h00, 1);
      ack_byte(8'h00, 1); ack_byte(8'h03, 1);
      expect_st(CMD, 1, 1, 0, 0, "R4 6-byte not done after 5");
      ack_byte(8'h00, 1);
      expect_st(DIN, 1, 1, 1, 8'hA0, "R4 R5 data in length from byte 4");
      cyc();
      expect_st(DIN, 1, 1, 1, 8'hA0, "R5 peek does not advance");
      rd_next_i = 1; cyc(); rd_next_i = 0;
      expect_st(DIN, 1, 1, 1, 8'hA1, "R5 consume via read port");
      ack_i = 1; cyc();
      expect_st(DIN, 1, 0, 1, 8'hA2, "R7 ack rise consumes inbound");
      ack_i = 0; cyc();
      expect_st(DIN, 1, 1, 1, 8'hA2, "R7 ack fall no effect");
      chk(tgt_idx_o == 16'd2, "R7 offset after fall", tgt_idx_o, 2);
      ack_i = 1; cyc();
      expect_st(STAT, 1, 0, 1, 8'h02, "R5 length reached -> status");
      ack_i = 0; cyc();
      expect_st(STAT, 1, 1, 1, 8'h02, "R6 status byte peek");
      ack_byte(8'h00, 0);
      expect_st(MSGI, 1, 1, 1, 8'h00, "R6 message-in after status");
      ack_byte(8'h00, 0);
      expect_st(FREE, 0, 0, 1, 8'h00, "R6 message consumed -> free");

      // Arbitration path, initiator excluded, 10-byte write command
      bsy_i = 1; dbus_i = 8'h01; cyc();
      expect_st(ARB, 0, 0, 0, 0, "R1 arbitrate id 0");
      sel_i = 1; cyc();
      expect_st(SEL, 0, 0, 0, 0, "R1 arbitration to selection");
      present_i = 8'h03; dbus_i = 8'h03; cyc();
      expect_st(SEL, 0, 0, 0, 0, "R3 wait while BSY high");
      bsy_i = 0; cyc();
      expect_st(CMD, 1, 1, 0, 0, "R3 command");
      chk(tgt_id_o == 3'd1, "R3 initiator excluded", tgt_id_o, 1);
      sel_i = 0; dir_in_i = 0; tgt_status_i = 8'h00;
      ack_byte(8'h2A, 1);
      for (int i = 1; i < 7; i++) ack_byte(8'h00, 1);
      ack_byte(8'h00, 1); ack_byte(8'h02, 1);
      expect_st(CMD, 1, 1, 0, 0, "R4 10-byte not done after 9");
      ack_byte(8'h00, 1);
      expect_st(DOUT, 1, 1, 0, 0, "R4 R5 data out length from bytes 7-8");
      ack_byte(8'h55, 0);
      expect_st(DOUT, 1, 1, 0, 0, "R7 undriven ack keeps data out");
      chk(wn == 0, "R7 no write when bus not driven", wn, 0);
      ack_byte(8'h11, 1);
      ack_byte(8'h22, 1);
      expect_st(STAT, 1, 1, 1, 8'h00, "R5 data out complete -> status");
      chk(wn == 2 && wlog[0] == 8'h11 && wlog[1] == 8'h22, "R7 bytes written",
          {wlog[0], wlog[1]}, 16'h1122);
      rd_next_i = 1; cyc();
      expect_st(MSGI, 1, 1, 1, 8'h00, "R6 consume status");
      cyc(); rd_next_i = 0;
      expect_st(FREE, 0, 0, 0, 0, "R6 consume message");

      // R4: explicit length overrides byte 4
      present_i = 8'h01; dir_in_i = 1; len_ovr_vld_i = 1; len_ovr_i = 16'd1;
      sel_from_free(8'h01);
      ack_byte(8'h08, 1);
      for (int i = 1; i < 4; i++) ack_byte(8'h00, 1);
      ack_byte(8'h09, 1); ack_byte(8'h00, 1);
      len_ovr_vld_i = 0;
      expect_st(DIN, 1, 1, 1, 8'hA0, "R4 override data in");
      rd_next_i = 1; cyc(); rd_next_i = 0;
      expect_st(STAT, 1, 1, 0, 0, "R4 override length 1 -> status");
      rd_next_i = 1; cyc(); cyc(); rd_next_i = 0;
      expect_st(FREE, 0, 0, 0, 0, "R6 back to free");

      // R5 zero length, then R9 reset mid-phase
      tgt_status_i = 8'h5A;
      sel_from_free(8'h01);
      for (int i = 0; i < 6; i++) ack_byte(8'h00, 1);
      expect_st(STAT, 1, 1, 1, 8'h5A, "R5 zero length -> status");
      rst = 1; cyc(); rst = 0;
      expect_st(FREE, 0, 0, 1, 8'h00, "R9 reset mid transfer");
      chk(!init_vld_o && tgt_idx_o == '0, "R9 ids and offset cleared", tgt_idx_o, 0);
      cyc(); cyc();
      done = 1;
   end

   initial begin
      for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: act=timeout exp=finish");
      end
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule